// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Byte Receiver

This block turns an asynchronous serial line into 8-bit parallel bytes. An external divider supplies a one-cycle enable at sixteen times the bit rate. The receiver uses that enable to time each bit period in sixteen steps. A frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. The serial input is resynchronised through two flops before any logic sees it.

While the line is idle, the receiver waits for a low level on an oversampling tick. That tick begins the start bit, and the busy flag rises on the next clock. Each bit is sampled on its 8th tick. A start bit that reads high at that point is dropped as a glitch. Each data bit is shifted in on its 8th tick, and the stop level is recorded on its 8th tick. On the 16th tick of the stop bit, the byte is moved to the output register. At the same moment a one-clock strobe is raised and busy falls. A low stop sample raises a framing-error pulse together with the strobe.

Top module: `uart_rx16`

## Requirements
- R1: While reset is held and after its release, `rx_byte` is 0, `rx_strobe` is 0, `rx_busy` is 0 and `frame_err` is 0.
- R2: The line is seen through two clocked stages. When idle, a tick with the resynchronised line low starts a frame, and `rx_busy` is 1 from the next clock.
- R3: On the 8th tick of the start bit the line is sampled again. If it is high, reception is abandoned and `rx_busy` returns to 0, with no strobe.
- R4: Each of the eight data bits is sampled on the 8th tick of its bit period. The first data bit received becomes bit 0 of `rx_byte` and the last becomes bit 7.
- R5: On the 16th tick of the stop bit, `rx_byte` takes the assembled byte and `rx_strobe` is high for exactly one clock.
- R6: `rx_busy` stays high from start detection until the end of the frame. It is low in the same clock in which `rx_strobe` is high.
- R7: If the stop bit sampled on its 8th tick is low, `frame_err` is high in the strobe clock, and only then. The byte is still delivered.
- R8: A high idle line has no effect however many ticks arrive: `rx_busy` stays 0, no strobe occurs and `rx_byte` keeps its value. `rx_byte` changes only in a strobe clock.
- R9: A start bit that follows the stop bit immediately, with no idle time, is received as a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-clock enable at sixteen times the bit rate |
| rxd | input | 1 | Asynchronous serial input, high when idle |
| rx_byte | output | 8 | Last received byte |
| rx_strobe | output | 1 | One-clock pulse when a new byte is in `rx_byte` |
| rx_busy | output | 1 | High while a frame is being received |
| frame_err | output | 1 | Pulse with the strobe when the stop bit was low |

## Verification
The bytes 0x55, 0xAA, 0x00, 0xFF, 0x01, 0x80 and 0xA5 are sent. Together they catch swapped bit order, stuck shift-register bits and an off-by-one bit count, because the single-bit patterns land at opposite ends of the byte. A short low pulse tells a true start bit from a glitch. A frame with a low stop bit separates good frames from framing errors. Back-to-back frames check that a new start bit is found right after the transfer tick. A long high idle period checks that ticks alone do nothing.

// File: rtl/uart_rx16_pkg.sv
package uart_rx16_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } rx_phase_e;
endpackage

// File: rtl/uart_rx16_sync.sv
module uart_rx16_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx16_timer.sv
module uart_rx16_timer #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic start,
    output logic mid_evt,
    output logic end_evt
);
    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start)      tmr_d.cnt = CW'(1);
        else if (!run)  tmr_d.cnt = '0;
        else if (tick)  tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign mid_evt = run && tick && (tmr_q.cnt == CW'(MID - 1));
    assign end_evt = run && tick && (tmr_q.cnt == CW'(OSR - 1));

    // R4
    run_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && !tick) |=> $stable(tmr_q.cnt));
endmodule

// File: rtl/uart_rx16_ctrl.sv
module uart_rx16_ctrl
    import uart_rx16_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 mid_evt,
    input  logic                 end_evt,
    output logic                 start,
    output logic                 run,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid,
    output logic                 ferr,
    output logic                 busy
);
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    typedef struct packed {
        rx_phase_e              phase;
        logic [BW-1:0]          bitcnt;
        logic [DATA_BITS-1:0]   shreg;
        logic                   stop_bad;
        logic [DATA_BITS-1:0]   data;
        logic                   valid;
        logic                   ferr;
        logic                   busy;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.ferr  = 1'b0;
        start      = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (tick && !line) begin
                    start      = 1'b1;
                    st_d.phase = PH_START;
                    st_d.busy  = 1'b1;
                end
            end
            PH_START: begin
                if (mid_evt && line) begin
                    st_d.phase = PH_IDLE;
                    st_d.busy  = 1'b0;
                end else if (end_evt) begin
                    st_d.phase  = PH_DATA;
                    st_d.bitcnt = '0;
                end
            end
            PH_DATA: begin
                if (mid_evt)
                    st_d.shreg = {line, st_q.shreg[DATA_BITS-1:1]};
                if (end_evt) begin
                    if (st_q.bitcnt == BW'(DATA_BITS - 1))
                        st_d.phase = PH_STOP;
                    else
                        st_d.bitcnt = st_q.bitcnt + 1'b1;
                end
            end
            PH_STOP: begin
                if (mid_evt)
                    st_d.stop_bad = !line;
                if (end_evt) begin
                    st_d.data  = st_q.shreg;
                    st_d.valid = 1'b1;
                    st_d.ferr  = st_q.stop_bad;
                    st_d.busy  = 1'b0;
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign run   = (st_q.phase != PH_IDLE);
    assign data  = st_q.data;
    assign valid = st_q.valid;
    assign ferr  = st_q.ferr;
    assign busy  = st_q.busy;

    // R2
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> ($past(tick) && !$past(line)));

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (!st_q.busy && $past(st_q.busy)));

    // R7
    ferr_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ferr |-> st_q.valid);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> $stable(st_q.data));
endmodule

// File: rtl/uart_rx16.sv
module uart_rx16 #(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_strobe,
    output logic                 rx_busy,
    output logic                 frame_err
);
    logic line_s;
    logic mid_evt, end_evt;
    logic start, run;

    uart_rx16_sync #(
        .STAGES   (SYNC_STAGES),
        .IDLE_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (line_s)
    );

    uart_rx16_timer #(
        .OSR (OSR)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .run     (run),
        .start   (start),
        .mid_evt (mid_evt),
        .end_evt (end_evt)
    );

    uart_rx16_ctrl #(
        .DATA_BITS (DATA_BITS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .line    (line_s),
        .mid_evt (mid_evt),
        .end_evt (end_evt),
        .start   (start),
        .run     (run),
        .data    (rx_byte),
        .valid   (rx_strobe),
        .ferr    (frame_err),
        .busy    (rx_busy)
    );
endmodule

// File: tb/tb_uart_rx16.sv
`timescale 1ns/1ps
module tb_uart_rx16;
    localparam int TDIV   = 4;
    localparam int BITCLK = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_strobe, rx_busy, frame_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx16 dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick16    (tick16),
        .rxd       (rxd),
        .rx_byte   (rx_byte),
        .rx_strobe (rx_strobe),
        .rx_busy   (rx_busy),
        .frame_err (frame_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Tick generator, driven away from the active edge
    int divcnt = 0;
    always @(negedge clk) begin
        tick16 <= (divcnt == TDIV - 1);
        divcnt  = (divcnt == TDIV - 1) ? 0 : divcnt + 1;
    end

    // Behavioural reference model
    bit         m_s1 = 1'b1, m_s2 = 1'b1, m_stopbad = 1'b0;
    int         m_phase = 0, m_ticks = 0, m_nbits = 0;
    logic [7:0] m_acc = '0;
    logic [7:0] e_data = '0;
    bit         e_stb = 1'b0, e_err = 1'b0, e_busy = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 1'b1; m_s2 = 1'b1; m_phase = 0; m_ticks = 0; m_nbits = 0;
            m_acc = '0; e_data = '0; e_stb = 1'b0; e_err = 1'b0; e_busy = 1'b0;
            m_stopbad = 1'b0;
        end else begin
            bit ln;
            ln = m_s2;
            e_stb = 1'b0;
            e_err = 1'b0;
            if (m_phase == 0) begin
                if (tick16 && !ln) begin
                    m_phase = 1; m_ticks = 1; e_busy = 1'b1;
                end
            end else if (tick16) begin
                m_ticks++;
                if (m_ticks == 8) begin
                    if (m_phase == 1 && ln) begin
                        m_phase = 0; e_busy = 1'b0;
                    end else if (m_phase == 2) begin
                        m_acc[m_nbits] = ln;
                    end else if (m_phase == 3) begin
                        m_stopbad = !ln;
                    end
                end else if (m_ticks == 16) begin
                    m_ticks = 0;
                    if (m_phase == 1) begin
                        m_phase = 2; m_nbits = 0;
                    end else if (m_phase == 2) begin
                        m_nbits++;
                        if (m_nbits == 8) m_phase = 3;
                    end else begin
                        e_data = m_acc; e_stb = 1'b1; e_err = m_stopbad;
                        e_busy = 1'b0; m_phase = 0;
                    end
                end
            end
            m_s2 = m_s1;
            m_s1 = rxd;
        end
    end

    // Per-clock comparison and capture of delivered bytes
    logic [7:0] rx_q[$];
    bit         err_q[$];
    int         strobes = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(rx_busy == e_busy,     "R6 busy",   rx_busy,   e_busy);
            chk(rx_strobe == e_stb,    "R5 strobe", rx_strobe, e_stb);
            chk(rx_byte == e_data,     "R4 byte",   rx_byte,   e_data);
            chk(frame_err == e_err,    "R7 ferr",   frame_err, e_err);
            if (rx_strobe) begin
                strobes++;
                rx_q.push_back(rx_byte);
                err_q.push_back(frame_err);
            end
        end
    end

    task automatic drive_bit(input bit v);
        rxd = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit stop_v);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit(stop_v);
        rxd = 1'b1;
    endtask

    task automatic expect_byte(input logic [7:0] b, input bit err);
        logic [7:0] got;
        bit         gerr;
        chk(rx_q.size() > 0, "R5 strobe count", rx_q.size(), 1);
        if (rx_q.size() > 0) begin
            got  = rx_q.pop_front();
            gerr = err_q.pop_front();
            chk(got == b,    "R4 byte value", got,  b);
            chk(gerr == err, "R7 error flag", gerr, err);
        end
    endtask

    task automatic idle(input int bits);
        rxd = 1'b1;
        repeat (bits * BITCLK) @(negedge clk);
    endtask

    initial begin
        logic [7:0] pats [7] = '{8'h55, 8'hAA, 8'h00, 8'hFF, 8'h01, 8'h80, 8'hA5};
        int s0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(rx_byte == 8'h00 && !rx_strobe && !rx_busy && !frame_err, "R1 reset", rx_busy, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rx_byte == 8'h00 && !rx_busy, "R1 after release", rx_byte, 0);

        // R8: idle line, ticks only
        s0 = strobes;
        idle(4);
        chk(!rx_busy,          "R8 idle busy",    rx_busy, 0);
        chk(strobes == s0,     "R8 idle strobe",  strobes - s0, 0);
        chk(rx_byte == 8'h00,  "R8 idle byte",    rx_byte, 0);

        // R4 R5 R6: a range of byte patterns
        foreach (pats[k]) begin
            send_frame(pats[k], 1'b1);
            idle(2);
            expect_byte(pats[k], 1'b0);
            chk(!rx_busy, "R6 busy after frame", rx_busy, 0);
        end

        // R3: short low pulse is a glitch
        s0 = strobes;
        rxd = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * TDIV) @(negedge clk);
        chk(rx_busy, "R2 busy on start", rx_busy, 1);
        idle(2);
        chk(!rx_busy,      "R3 glitch busy",   rx_busy, 0);
        chk(strobes == s0, "R3 glitch strobe", strobes - s0, 0);
        chk(rx_byte == 8'hA5, "R3 byte kept",  rx_byte, 8'hA5);

        // R7: low stop bit
        send_frame(8'h3C, 1'b0);
        idle(2);
        expect_byte(8'h3C, 1'b1);

        // R9: back-to-back frames
        send_frame(8'hC3, 1'b1);
        send_frame(8'h96, 1'b1);
        send_frame(8'h7E, 1'b1);
        idle(2);
        expect_byte(8'hC3, 1'b0);
        expect_byte(8'h96, 1'b0);
        expect_byte(8'h7E, 1'b0);
        chk(rx_q.size() == 0, "R9 no extra bytes", rx_q.size(), 0);

        // R8: long idle holds the last byte
        idle(3);
        chk(rx_byte == 8'h7E && !rx_busy, "R8 hold", rx_byte, 8'h7E);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule